// File: doc/BRIEF.md
# Interrupt Routing and Priority Controller

This block gathers a wide set of level-sensitive peripheral interrupt sources and steers each one onto one of 32 numbered CPU interrupt lines (lines 1 to 31 can be used; line 0 is reserved). Software chooses the route by writing a line number into a per-source routing word. A line can be enabled or disabled one bit at a time. Each usable line has a 4-bit priority. A single global 4-bit threshold keeps lines at or below its level from interrupting.

The controller decides which line is active. It then sends the CPU one request bit and the 5-bit number of the winning line. Both outputs come from registers. Configuration is reached through a simple byte-addressed, word-wide read/write bus. Its read data comes from a register.

Top module: `irq_route_ctrl`

## Requirements
- R1: After synchronous reset, `irq_o` and `irq_id_o` are 0, `bus_rdata` is 0, and every routing word, the enable word, every priority and the threshold read back as 0.
- R2: Source s has a routing word at byte offset 4*s. It keeps bits [4:0] of the written data and reads back those bits, with the upper bits 0. A routing value of 0 leaves the source unrouted.
- R3: The line enable word is at byte offset 0x104. It keeps all 32 bits, and bit n enables line n. A disabled line never raises a request.
- R4: Line n (1 to 31) has its priority in bits [3:0] of the word at byte offset 0x118 + 4*(n-1), so line 31 is at 0x190. Line 0 has no priority word and is never reported.
- R5: The threshold is in bits [3:0] of the word at byte offset 0x194. A pending line is eligible only when its priority is strictly greater than the threshold. This means priority 0 never interrupts and threshold 15 blocks every line.
- R6: A line is pending when its enable bit is set and at least one asserted source is routed to it. Several sources on one line combine as an OR.
- R7: Of the eligible lines, the line with the numerically highest priority wins.
- R8: When two or more eligible lines share the highest priority, the line with the lowest number wins.
- R9: `irq_o` and `irq_id_o` come from registers. They show the sources and configuration as they were at the previous rising clock edge. When no line is eligible, `irq_o` is 0 and `irq_id_o` is 0.
- R10: A read of any offset not listed above returns 0. A write to such an offset changes no register.
- R11: `bus_rdata` is valid one cycle after a cycle with `bus_rd` high, and is 0 after a cycle without a read. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level interrupt sources |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_id_o | output | 5 | Number of the winning line |

## Verification
A source change applied between clock edges shows up on `irq_o`/`irq_id_o` right after the next rising edge. The bench first samples just before that edge, where the old value must still be present, and then just after it. A configuration write is captured at one edge and affects the outputs at the edge after that, so every arbitration check is placed one full cycle after the write strobe drops. Read data is taken one cycle after the read strobe. The following idle cycle is also checked, to confirm that the data returns to zero.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int LINE_CNT  = 32;
    localparam int LINE_ID_W = $clog2(LINE_CNT);
    localparam int PRIO_W    = 4;
    localparam int DATA_W    = 32;

    // word indices (byte offset / 4) of the fixed registers
    localparam int WORD_ENABLE = 'h104 / 4;
    localparam int WORD_PRIO1  = 'h118 / 4;
    localparam int WORD_PRIO31 = WORD_PRIO1 + LINE_CNT - 2;
    localparam int WORD_THRESH = 'h194 / 4;

    typedef logic [LINE_ID_W-1:0] line_id_t;
    typedef logic [PRIO_W-1:0]    prio_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_ROUTE,
        RK_ENABLE,
        RK_PRIO,
        RK_THRESH
    } reg_kind_t;

    typedef struct packed {
        logic     valid;
        prio_t    prio;
        line_id_t id;
    } cand_t;

    // lo covers the lower line numbers; it keeps ties
    function automatic cand_t pick_cand(cand_t lo, cand_t hi);
        if (lo.valid && (!hi.valid || lo.prio >= hi.prio))
            return lo;
        return hi;
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 62,
    parameter int ADDR_W  = 10
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output line_id_t                  route_o [NUM_SRC],
    output logic [LINE_CNT-1:0]       enable_o,
    output prio_t                     prio_o  [LINE_CNT],
    output prio_t                     thresh_o
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    reg_kind_t         kind;
    logic              unused_lo;
    logic [DATA_W-1:0] rd_val;

    assign word      = bus_addr[ADDR_W-1:2];
    assign unused_lo = ^bus_addr[1:0];

    always_comb begin
        kind = RK_NONE;
        if (int'(word) < NUM_SRC)
            kind = RK_ROUTE;
        else if (int'(word) == WORD_ENABLE)
            kind = RK_ENABLE;
        else if (int'(word) >= WORD_PRIO1 && int'(word) <= WORD_PRIO31)
            kind = RK_PRIO;
        else if (int'(word) == WORD_THRESH)
            kind = RK_THRESH;
    end

    // routing words, one per source
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_route
        line_id_t route_q;
        always_ff @(posedge clk) begin
            if (rst)
                route_q <= '0;
            else if (bus_wr && kind == RK_ROUTE && int'(word) == s)
                route_q <= bus_wdata[LINE_ID_W-1:0];
        end
        assign route_o[s] = route_q;
    end

    // per-line priorities; line 0 has none
    assign prio_o[0] = '0;
    for (genvar n = 1; n < LINE_CNT; n++) begin : g_prio
        prio_t prio_q;
        always_ff @(posedge clk) begin
            if (rst)
                prio_q <= '0;
            else if (bus_wr && kind == RK_PRIO && int'(word) == WORD_PRIO1 + n - 1)
                prio_q <= bus_wdata[PRIO_W-1:0];
        end
        assign prio_o[n] = prio_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_o <= '0;
            thresh_o <= '0;
        end else if (bus_wr) begin
            if (kind == RK_ENABLE)
                enable_o <= bus_wdata;
            if (kind == RK_THRESH)
                thresh_o <= bus_wdata[PRIO_W-1:0];
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (kind)
            RK_ROUTE: begin
                for (int s = 0; s < NUM_SRC; s++)
                    if (int'(word) == s)
                        rd_val = DATA_W'(route_o[s]);
            end
            RK_ENABLE: rd_val = enable_o;
            RK_PRIO: begin
                for (int n = 1; n < LINE_CNT; n++)
                    if (int'(word) == WORD_PRIO1 + n - 1)
                        rd_val = DATA_W'(prio_o[n]);
            end
            RK_THRESH: rd_val = DATA_W'(thresh_o);
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else
            bus_rdata <= bus_rd ? rd_val : '0;
    end

endmodule

// File: rtl/irq_route_fanin.sv
module irq_route_fanin
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 62
) (
    input  logic [NUM_SRC-1:0]  src_i,
    input  line_id_t            route_i [NUM_SRC],
    input  logic [LINE_CNT-1:0] enable_i,
    output logic [LINE_CNT-1:0] pend_o
);

    assign pend_o[0] = 1'b0;

    for (genvar n = 1; n < LINE_CNT; n++) begin : g_line
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int s = 0; s < NUM_SRC; s++)
                if (src_i[s] && route_i[s] == line_id_t'(n))
                    hit = 1'b1;
        end
        assign pend_o[n] = hit && enable_i[n];
    end

endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb
    import irq_route_pkg::*;
(
    input  logic [LINE_CNT-1:0] pend_i,
    input  prio_t               prio_i [LINE_CNT],
    input  prio_t               thresh_i,
    output cand_t               win_o
);

    localparam int NODES = 2 * LINE_CNT - 1;
    localparam int LEAF0 = LINE_CNT - 1;

    cand_t node [NODES];

    // leaves in line order: the left subtree always holds lower lines
    for (genvar n = 0; n < LINE_CNT; n++) begin : g_leaf
        assign node[LEAF0+n].valid = pend_i[n] && (prio_i[n] > thresh_i);
        assign node[LEAF0+n].prio  = prio_i[n];
        assign node[LEAF0+n].id    = line_id_t'(n);
    end

    for (genvar i = 0; i < LEAF0; i++) begin : g_node
        assign node[i] = pick_cand(node[2*i+1], node[2*i+2]);
    end

    assign win_o = node[0];

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 62,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_o,
    output logic [4:0]         irq_id_o
);

    line_id_t            cfg_route [NUM_SRC];
    logic [LINE_CNT-1:0] cfg_en;
    prio_t               cfg_prio [LINE_CNT];
    prio_t               cfg_thr;
    logic [LINE_CNT-1:0] pend;
    cand_t               win;

    irq_route_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .route_o   (cfg_route),
        .enable_o  (cfg_en),
        .prio_o    (cfg_prio),
        .thresh_o  (cfg_thr)
    );

    irq_route_fanin #(.NUM_SRC(NUM_SRC)) u_fanin (
        .src_i    (src_i),
        .route_i  (cfg_route),
        .enable_i (cfg_en),
        .pend_o   (pend)
    );

    irq_route_arb u_arb (
        .pend_i   (pend),
        .prio_i   (cfg_prio),
        .thresh_i (cfg_thr),
        .win_o    (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o    <= 1'b0;
            irq_id_o <= '0;
        end else begin
            irq_o    <= win.valid;
            irq_id_o <= win.valid ? win.id : '0;
        end
    end

endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk #(
    parameter int NUM_SRC = 62,
    parameter int ADDR_W  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_o,
    input logic [4:0]        irq_id_o,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       cfg_en,
    input logic [3:0]        cfg_thr
);

    int   w;
    logic rsv;
    logic [31:0] en_d;

    always_comb begin
        w   = int'(bus_addr[ADDR_W-1:2]);
        rsv = !(w < NUM_SRC || w == 'h41 || (w >= 'h46 && w <= 'h65));
    end

    always_ff @(posedge clk) en_d <= cfg_en;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!irq_o && bus_rdata == 32'd0));

    assert_idle_id_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> irq_id_o == 5'd0);

    assert_no_line_zero_R4: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> irq_id_o != 5'd0);

    assert_enabled_winner_R3: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> en_d[irq_id_o]);

    assert_full_threshold_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_thr == 4'hF |=> !irq_o);

    assert_reserved_read_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && rsv) |=> bus_rdata == 32'd0);

    assert_no_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> bus_rdata == 32'd0);

endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_o     (irq_o),
    .irq_id_o  (irq_id_o),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cfg_en    (cfg_en),
    .cfg_thr   (cfg_thr)
);

// File: tb/irq_route_ctrl_bench.sv
module irq_route_ctrl_bench;

    localparam int NSRC = 62;
    localparam int AW   = 10;
    localparam logic [AW-1:0] A_EN  = 10'h104;
    localparam logic [AW-1:0] A_THR = 10'h194;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_o;
    logic [4:0]      irq_id_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    irq_route_ctrl #(.NUM_SRC(NSRC), .ADDR_W(AW)) u_irq_route_ctrl (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .irq_id_o  (irq_id_o)
    );

    function automatic logic [AW-1:0] a_route(int s);
        return AW'(s * 4);
    endfunction

    function automatic logic [AW-1:0] a_prio(int n);
        return AW'('h118 + 4 * (n - 1));
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; src = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_out(input string req, input logic irq, input logic [4:0] id);
        chk(req, {31'd0, irq_o}, {31'd0, irq});
        chk(req, {27'd0, irq_id_o}, {27'd0, id});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk_out("R1 outputs", 1'b0, 5'd0);
        chk("R1 rdata", bus_rdata, 32'd0);
        rd(A_EN, d);       chk("R1 enable", d, 32'd0);
        rd(A_THR, d);      chk("R1 threshold", d, 32'd0);
        rd(a_route(3), d); chk("R1 route", d, 32'd0);
        rd(a_prio(1), d);  chk("R1 prio", d, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        do_reset();
        wr(a_route(3), 32'd7);          rd(a_route(3), d); chk("R2 route readback", d, 32'd7);
        wr(a_route(5), 32'hFFFF_FFFF);  rd(a_route(5), d); chk("R2 route field width", d, 32'h1F);
        wr(A_EN, 32'hA5A5_A5A5);        rd(A_EN, d);       chk("R3 enable readback", d, 32'hA5A5_A5A5);
        wr(a_prio(1), 32'h0000_0FFF);   rd(a_prio(1), d);  chk("R4 prio line1", d, 32'hF);
        wr(10'h190, 32'd3);             rd(a_prio(31), d); chk("R4 prio line31", d, 32'd3);
        wr(A_THR, 32'h27);              rd(A_THR, d);      chk("R5 threshold field", d, 32'd7);
        rd(10'h106, d);                 chk("R11 low addr bits ignored", d, 32'hA5A5_A5A5);
        tick();                         chk("R11 idle rdata", bus_rdata, 32'd0);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        do_reset();
        wr(10'h108, 32'hFFFF_FFFF);
        wr(10'h114, 32'hFFFF_FFFF);
        wr(10'h0F8, 32'hFFFF_FFFF);
        wr(10'h198, 32'hFFFF_FFFF);
        rd(10'h108, d);     chk("R10 read 0x108", d, 32'd0);
        rd(10'h114, d);     chk("R10 read 0x114", d, 32'd0);
        rd(10'h0F8, d);     chk("R10 read 0xF8", d, 32'd0);
        rd(10'h198, d);     chk("R10 read 0x198", d, 32'd0);
        rd(A_EN, d);        chk("R10 enable untouched", d, 32'd0);
        rd(A_THR, d);       chk("R10 threshold untouched", d, 32'd0);
        rd(a_prio(31), d);  chk("R10 prio untouched", d, 32'd0);
        rd(a_route(NSRC-1), d); chk("R10 last route untouched", d, 32'd0);
        chk_out("R10 outputs idle", 1'b0, 5'd0);
    endtask

    task automatic t_route();
        do_reset();
        wr(a_route(3), 32'd7);
        wr(a_prio(7), 32'd5);
        wr(A_EN, 32'h80);
        src[3] = 1'b1;
        tick(); chk_out("R6 routed source", 1'b1, 5'd7);
        wr(A_EN, 32'h0);
        tick(); chk_out("R3 line disabled", 1'b0, 5'd0);
        wr(A_EN, 32'h80);
        wr(a_route(3), 32'd0);
        tick(); chk_out("R2 unrouted source", 1'b0, 5'd0);
        wr(A_EN, 32'h1);
        tick(); chk_out("R4 line0 never reported", 1'b0, 5'd0);
    endtask

    task automatic t_thresh();
        do_reset();
        wr(a_route(3), 32'd7);
        wr(a_prio(7), 32'd5);
        wr(A_EN, 32'h80);
        wr(A_THR, 32'd5);
        src[3] = 1'b1;
        tick(); chk_out("R5 prio equal to threshold", 1'b0, 5'd0);
        wr(A_THR, 32'd4);
        tick(); chk_out("R5 prio above threshold", 1'b1, 5'd7);
        wr(A_THR, 32'd15);
        wr(a_prio(7), 32'd15);
        tick(); chk_out("R5 threshold 15", 1'b0, 5'd0);
        wr(A_THR, 32'd0);
        wr(a_prio(7), 32'd0);
        tick(); chk_out("R5 prio 0 masks", 1'b0, 5'd0);
    endtask

    task automatic t_arb();
        do_reset();
        wr(a_route(1), 32'd7);  wr(a_prio(7), 32'd5);
        wr(a_route(2), 32'd9);  wr(a_prio(9), 32'd9);
        wr(a_route(4), 32'd4);  wr(a_prio(4), 32'd9);
        wr(a_route(10), 32'd31); wr(a_prio(31), 32'd15);
        wr(A_EN, 32'hFFFF_FFFF);
        src[1] = 1'b1; src[2] = 1'b1;
        tick(); chk_out("R7 higher prio wins", 1'b1, 5'd9);
        @(negedge clk); src[4] = 1'b1;
        tick(); chk_out("R8 tie lowest line", 1'b1, 5'd4);
        @(negedge clk); src[10] = 1'b1;
        tick(); chk_out("R7 top line highest prio", 1'b1, 5'd31);
        @(negedge clk); src[10] = 1'b0; src[4] = 1'b0;
        tick(); chk_out("R7 back to line 9", 1'b1, 5'd9);
    endtask

    task automatic t_or();
        do_reset();
        wr(a_route(20), 32'd12);
        wr(a_route(21), 32'd12);
        wr(a_prio(12), 32'd2);
        wr(A_EN, 32'h1000);
        src[20] = 1'b1; src[21] = 1'b1;
        tick(); chk_out("R6 two sources", 1'b1, 5'd12);
        @(negedge clk); src[20] = 1'b0;
        tick(); chk_out("R6 one source left", 1'b1, 5'd12);
        @(negedge clk); src[21] = 1'b0;
        tick(); chk_out("R6 no source", 1'b0, 5'd0);
    endtask

    task automatic t_latency();
        do_reset();
        wr(a_route(3), 32'd7);
        wr(a_prio(7), 32'd5);
        wr(A_EN, 32'h80);
        tick();
        @(negedge clk); src[3] = 1'b1;
        #1; chk_out("R9 before edge", 1'b0, 5'd0);
        tick(); chk_out("R9 after edge", 1'b1, 5'd7);
        @(negedge clk); src[3] = 1'b0;
        #1; chk_out("R9 held before edge", 1'b1, 5'd7);
        tick(); chk_out("R9 cleared after edge", 1'b0, 5'd0);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_reserved();
        t_route();
        t_thresh();
        t_arb();
        t_or();
        t_latency();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule